// File: doc/BRIEF.md
# Paired Event-State Page Controller

This block holds a two-bit pending/queued (P/Q) state for each of `N_QUEUES` event queues and lets software reach it through 64-bit loads and stores. Every queue has two separate states. One gates notifications and the other gates escalations. Each queue owns two adjacent pages. The even page of the pair reaches the notification state and the odd page reaches the escalation state.

The offset inside a page chooses the operation. Stores can trigger, end an interrupt, or inject. Loads can end an interrupt, query, or force a new value. Each accepted request gets one response in the following cycle. A store whose operation asks for it also raises a one-cycle notify pulse that names the queue and the state it came from. The block does not route that notification anywhere. The block assumes `PAGE_SHIFT` is 12 or 16 and that `N_QUEUES` is at least 1.

Top module: `esb_mmio`

## Requirements
- R1: During reset and right after it, every state of every queue reads as 00 (P is bit 1, Q is bit 0). `rsp_valid` and `notify_pulse` are low.
- R2: The queue number is `req_addr >> (PAGE_SHIFT+1)`. Address bit `PAGE_SHIFT` picks the notification state (0) or the escalation state (1). Address bits between 11 and `PAGE_SHIFT` are ignored. The two states of a queue never affect each other, and no queue affects another queue.
- R3: An accepted request (`req_valid` high at a clock edge) gives exactly one cycle of `rsp_valid` after that edge. An idle cycle gives no response.
- R4: A load at offset 0x800–0xBFF returns the state in data bits [1:0] with all other bits zero. The state does not change.
- R5: A load at offset 0xC00–0xFFF returns the old state in bits [1:0] and then writes the new state from offset bits [9:8].
- R6: A load at offset 0x000–0x7FF ends the interrupt. If Q was 1, the state becomes 10 and the data is 1. Otherwise the state becomes 00 and the data is 0. This load never raises `notify_pulse`.
- R7: A store at offset 0x000–0x3FF triggers the state. 00 goes to 10 and raises notify. 10 and 11 go to 11. 01 stays 01. Only the 00 case raises notify.
- R8: A store at offset 0x400–0x7FF ends the interrupt under the rule of R6, and raises notify when Q was 1.
- R9: A store at offset 0x800–0xBFF on an even page raises notify and leaves the state alone. The same store on an odd page is an error: there is no notify and no change.
- R10: Any of these is an error: a size other than 8 bytes, a queue number of `N_QUEUES` or more, a store at offset 0xC00–0xFFF, or an odd-page inject. An error sets `rsp_err`, returns all-ones data, changes no state, and raises no notify. A store that succeeds returns zero data.
- R11: While `notify_pulse` is high, `notify_queue` and `notify_escal` name the queue and the state that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 4 | Access size in bytes (only 8 is legal) |
| req_addr | input | ADDR_W | Byte address inside the block window |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_data | output | 64 | Load result (zero for a store that succeeds) |
| rsp_err | output | 1 | Request was rejected |
| notify_pulse | output | 1 | A store asked for a notification |
| notify_queue | output | SEL_W | Queue that caused the notification |
| notify_escal | output | 1 | 1 if the escalation state caused it |

## Verification
One state is driven through all four of its values, and every operation is applied from each value it can meet. This shows that trigger and end-of-interrupt follow their rules and do not simply copy or clear the state. The end-of-interrupt is exercised from both the load side and the store side, and at the top and bottom of each offset range, to check the range edges. The even and odd pages of one queue are driven apart and then compared. A second queue and a neighbouring queue are also read, which checks that the index and parity decode keep states separate. A second instance with 64 KiB pages checks that the wider page ignores the middle address bits. Rejected accesses are each followed by a query, which shows at the ports that no state moved.

// File: rtl/esb_pkg.sv
// Shared types for the paired event-state page controller.
// Assumes P is held in bit 1 and Q in bit 0 of every state.
package esb_pkg;

    typedef logic [1:0] pq_t;

    localparam pq_t PQ_RESET = 2'b00;
    localparam int  OFF_W    = 12;

    // Operation chosen by access direction and page offset.
    typedef enum logic [2:0] {
        OP_LD_EOI,
        OP_LD_QUERY,
        OP_LD_SET,
        OP_ST_TRIG,
        OP_ST_EOI,
        OP_ST_INJECT,
        OP_BAD
    } esb_op_e;

endpackage

// File: rtl/esb_decode.sv
// Address decoder: splits a request address into queue number, page parity,
// operation and forced value, and flags every illegal access.
// Assumes PAGE_SHIFT >= 12 so the operation offset sits below the parity bit.
module esb_decode
    import esb_pkg::*;
#(
    parameter int PAGE_SHIFT = 12,
    parameter int ADDR_W     = 24,
    parameter int N_QUEUES   = 6,
    parameter int SEL_W      = 3
) (
    input  logic              we,
    input  logic [3:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output esb_op_e           op,
    output logic [SEL_W-1:0]  queue,
    output logic              odd,
    output pq_t               set_val,
    output logic              fault
);
    localparam int IDX_W = ADDR_W - PAGE_SHIFT - 1;

    logic [IDX_W-1:0] idx_full;
    logic [OFF_W-1:0] off;
    logic             in_range;

    assign idx_full = addr[ADDR_W-1:PAGE_SHIFT+1];
    assign off      = addr[OFF_W-1:0];
    assign odd      = addr[PAGE_SHIFT];
    assign queue    = idx_full[SEL_W-1:0];
    assign set_val  = off[9:8];
    assign in_range = (int'(idx_full) < N_QUEUES);

    // Map direction and offset range onto an operation.
    always_comb begin
        if (we) begin
            unique case (off[11:10])
                2'b00:   op = OP_ST_TRIG;
                2'b01:   op = OP_ST_EOI;
                2'b10:   op = OP_ST_INJECT;
                default: op = OP_BAD;
            endcase
        end else begin
            if (!off[11])        op = OP_LD_EOI;
            else if (!off[10])   op = OP_LD_QUERY;
            else                 op = OP_LD_SET;
        end
    end

    // Collect every reason to reject the access.
    always_comb begin
        fault = (size != 4'd8) || !in_range || (op == OP_BAD)
                || ((op == OP_ST_INJECT) && odd);
    end

endmodule

// File: rtl/esb_pq_alu.sv
// Next-state logic for one two-bit state: computes the updated state,
// the small load result and whether a notification is due.
// Purely combinational; assumes the caller discards results on a fault.
module esb_pq_alu
    import esb_pkg::*;
(
    input  esb_op_e    op,
    input  pq_t        cur,
    input  pq_t        set_val,
    output pq_t        nxt,
    output logic [1:0] ld_data,
    output logic       notify
);
    logic flag;

    // Apply the selected operation to the current state.
    always_comb begin
        nxt     = cur;
        flag    = 1'b0;
        ld_data = 2'b00;
        unique case (op)
            OP_LD_EOI, OP_ST_EOI: begin
                flag = cur[0];
                nxt  = cur[0] ? 2'b10 : 2'b00;
                if (op == OP_LD_EOI) ld_data = {1'b0, cur[0]};
            end
            OP_LD_QUERY: ld_data = cur;
            OP_LD_SET: begin
                nxt     = set_val;
                ld_data = cur;
            end
            OP_ST_TRIG: begin
                unique case (cur)
                    2'b00: begin nxt = 2'b10; flag = 1'b1; end
                    2'b01: nxt = 2'b01;
                    default: nxt = 2'b11;
                endcase
            end
            OP_ST_INJECT: flag = 1'b1;
            default: ;
        endcase
    end

    // Only stores may ask for a notification.
    always_comb begin
        notify = flag && (op inside {OP_ST_TRIG, OP_ST_EOI, OP_ST_INJECT});
    end

endmodule

// File: rtl/esb_state_file.sv
// Register file holding a notification state and an escalation state per
// queue. One combinational read port and one write port.
// Assumes the writer only enables a write for an in-range queue.
module esb_state_file
    import esb_pkg::*;
#(
    parameter int N_QUEUES = 6,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rd_queue,
    input  logic             rd_odd,
    output pq_t              rd_val,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_queue,
    input  logic             wr_odd,
    input  pq_t              wr_val
);
    pq_t ntf_q [N_QUEUES];
    pq_t esc_q [N_QUEUES];

    for (genvar g = 0; g < N_QUEUES; g++) begin : g_queue
        // Hold and update the two states of queue g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ntf_q[g] <= PQ_RESET;
                esc_q[g] <= PQ_RESET;
            end else if (wr_en && (int'(wr_queue) == g)) begin
                if (wr_odd) esc_q[g] <= wr_val;
                else        ntf_q[g] <= wr_val;
            end
        end
    end

    // Select the addressed state; out-of-range queues read as reset value.
    always_comb begin
        rd_val = PQ_RESET;
        for (int i = 0; i < N_QUEUES; i++) begin
            if (int'(rd_queue) == i) rd_val = rd_odd ? esc_q[i] : ntf_q[i];
        end
    end

endmodule

// File: rtl/esb_mmio.sv
// Top of the paired event-state page controller. It decodes one access per
// cycle, updates the addressed state and registers the response and notify.
// Assumes PAGE_SHIFT is 12 or 16 and N_QUEUES >= 1. Store data is not used.
module esb_mmio
    import esb_pkg::*;
#(
    parameter int PAGE_SHIFT = 12,
    parameter int N_QUEUES   = 6,
    parameter int ADDR_W     = 24,
    localparam int SEL_W     = (N_QUEUES > 1) ? $clog2(N_QUEUES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [3:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic              rsp_err,
    output logic              notify_pulse,
    output logic [SEL_W-1:0]  notify_queue,
    output logic              notify_escal
);
    esb_op_e          op;
    logic [SEL_W-1:0] queue;
    logic             odd;
    pq_t              set_val;
    logic             fault;
    pq_t              cur;
    pq_t              nxt;
    logic [1:0]       ld_data;
    logic             alu_notify;
    logic             wr_en;

    esb_decode #(
        .PAGE_SHIFT (PAGE_SHIFT),
        .ADDR_W     (ADDR_W),
        .N_QUEUES   (N_QUEUES),
        .SEL_W      (SEL_W)
    ) u_decode (
        .we      (req_we),
        .size    (req_size),
        .addr    (req_addr),
        .op      (op),
        .queue   (queue),
        .odd     (odd),
        .set_val (set_val),
        .fault   (fault)
    );

    esb_state_file #(
        .N_QUEUES (N_QUEUES),
        .SEL_W    (SEL_W)
    ) u_states (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_queue (queue),
        .rd_odd   (odd),
        .rd_val   (cur),
        .wr_en    (wr_en),
        .wr_queue (queue),
        .wr_odd   (odd),
        .wr_val   (nxt)
    );

    esb_pq_alu u_alu (
        .op      (op),
        .cur     (cur),
        .set_val (set_val),
        .nxt     (nxt),
        .ld_data (ld_data),
        .notify  (alu_notify)
    );

    // Write back only for a legal access whose state actually moves.
    always_comb begin
        wr_en = req_valid && !fault && (nxt != cur);
    end

    // Register the response and the notify pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            rsp_err      <= 1'b0;
            notify_pulse <= 1'b0;
            notify_queue <= '0;
            notify_escal <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_err      <= req_valid && fault;
            notify_pulse <= req_valid && !fault && alu_notify;
            if (req_valid) begin
                rsp_data     <= fault ? '1 : {62'b0, ld_data};
                notify_queue <= queue;
                notify_escal <= odd;
            end
        end
    end

endmodule

// File: rtl/esb_mmio_chk.sv
// Port-level checker for esb_mmio, attached to every instance by bind.
module esb_mmio_chk #(
    parameter int PAGE_SHIFT = 12,
    parameter int ADDR_W     = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic [3:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [63:0]       rsp_data,
    input logic              rsp_err,
    input logic              notify_pulse
);
    a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r3_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r6_load_never_notifies: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we) |=> !notify_pulse);

    a_r10_bad_size_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 4'd8) |=> (rsp_err && rsp_data == '1));

    a_r9_odd_inject_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && req_addr[PAGE_SHIFT] && req_addr[11:10] == 2'b10)
        |=> (rsp_err && !notify_pulse));

    a_r10_err_blocks_notify: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !notify_pulse);

    a_r11_notify_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        notify_pulse |-> rsp_valid);
endmodule

bind esb_mmio esb_mmio_chk #(
    .PAGE_SHIFT (PAGE_SHIFT),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_we       (req_we),
    .req_size     (req_size),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_err      (rsp_err),
    .notify_pulse (notify_pulse)
);

// File: tb/sim_esb_mmio.sv
module sim_esb_mmio;
    localparam int CLK_PERIOD = 10;
    localparam int AW0 = 24;
    localparam int AW1 = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Instance with 4 KiB pages
    logic           req_valid = 0, req_we = 0;
    logic [3:0]     req_size = 4'd8;
    logic [AW0-1:0] req_addr = '0;
    logic           rsp_valid, rsp_err, notify_pulse, notify_escal;
    logic [63:0]    rsp_data;
    logic [2:0]     notify_queue;

    esb_mmio #(.PAGE_SHIFT(12), .N_QUEUES(6), .ADDR_W(AW0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_size(req_size), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .notify_pulse(notify_pulse),
        .notify_queue(notify_queue), .notify_escal(notify_escal));

    // Instance with 64 KiB pages
    logic           b_valid = 0, b_we = 0;
    logic [AW1-1:0] b_addr = '0;
    logic           b_rsp_valid, b_rsp_err, b_notify, b_escal;
    logic [63:0]    b_data;
    logic [1:0]     b_queue;

    esb_mmio #(.PAGE_SHIFT(16), .N_QUEUES(4), .ADDR_W(AW1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_we(b_we),
        .req_size(4'd8), .req_addr(b_addr), .rsp_valid(b_rsp_valid),
        .rsp_data(b_data), .rsp_err(b_rsp_err), .notify_pulse(b_notify),
        .notify_queue(b_queue), .notify_escal(b_escal));

    typedef struct packed {
        logic        we;
        logic [3:0]  idx;
        logic        odd;
        logic [11:0] off;
        logic [1:0]  d;
        logic        n;
        logic        e;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd2, 1'b0, 12'h800, 2'd0, 1'b0, 1'b0},
        '{1'b1, 4'd2, 1'b0, 12'h000, 2'd0, 1'b1, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'h800, 2'd2, 1'b0, 1'b0},
        '{1'b1, 4'd2, 1'b0, 12'h3F8, 2'd0, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'h800, 2'd3, 1'b0, 1'b0},
        '{1'b1, 4'd2, 1'b0, 12'h400, 2'd0, 1'b1, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'hBF8, 2'd2, 1'b0, 1'b0},
        '{1'b1, 4'd2, 1'b0, 12'h7F8, 2'd0, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'hD00, 2'd0, 1'b0, 1'b0},
        '{1'b1, 4'd2, 1'b0, 12'h000, 2'd0, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'h800, 2'd1, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'h000, 2'd1, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'h800, 2'd2, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'h000, 2'd0, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'hF00, 2'd0, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'h7F8, 2'd1, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'hC00, 2'd2, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'h800, 2'd0, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b1, 12'h800, 2'd0, 1'b0, 1'b0},
        '{1'b1, 4'd2, 1'b1, 12'h000, 2'd0, 1'b1, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'h800, 2'd0, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b1, 12'h800, 2'd2, 1'b0, 1'b0},
        '{1'b1, 4'd2, 1'b0, 12'h800, 2'd0, 1'b1, 1'b0},
        '{1'b0, 4'd2, 1'b0, 12'h800, 2'd0, 1'b0, 1'b0},
        '{1'b1, 4'd2, 1'b1, 12'h800, 2'd0, 1'b0, 1'b1},
        '{1'b0, 4'd2, 1'b1, 12'h800, 2'd2, 1'b0, 1'b0},
        '{1'b1, 4'd5, 1'b0, 12'h000, 2'd0, 1'b1, 1'b0},
        '{1'b0, 4'd5, 1'b0, 12'h800, 2'd2, 1'b0, 1'b0},
        '{1'b0, 4'd0, 1'b0, 12'h800, 2'd0, 1'b0, 1'b0},
        '{1'b0, 4'd6, 1'b0, 12'h800, 2'd0, 1'b0, 1'b1},
        '{1'b1, 4'd6, 1'b0, 12'h000, 2'd0, 1'b0, 1'b1},
        '{1'b1, 4'd2, 1'b0, 12'hC00, 2'd0, 1'b0, 1'b1},
        '{1'b0, 4'd2, 1'b0, 12'h800, 2'd0, 1'b0, 1'b0},
        '{1'b0, 4'd5, 1'b1, 12'h800, 2'd0, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b1, 12'hE00, 2'd2, 1'b0, 1'b0},
        '{1'b0, 4'd2, 1'b1, 12'h800, 2'd2, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW0-1:0] a0(input int idx, input bit odd,
                                          input logic [11:0] off);
        return AW0'((idx << 13) | (int'(odd) << 12) | int'(off));
    endfunction

    function automatic string req_tag(input vec_t v);
        if (v.we && v.off[11:10] == 2'b10) return "R9";
        if (v.e)                           return "R10";
        if (v.we) return v.off[10] ? "R8" : "R7";
        if (!v.off[11]) return "R6";
        return v.off[10] ? "R5" : "R4";
    endfunction

    // One request on u0; outputs are then stable until the next rising edge.
    task automatic issue(input logic we, input logic [3:0] sz, input logic [AW0-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_size = sz; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_size = 4'd8;
    endtask

    task automatic issue1(input logic we, input logic [AW1-1:0] a);
        @(negedge clk);
        b_valid = 1'b1; b_we = we; b_addr = a;
        @(negedge clk);
        b_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while held in reset
        check(!rsp_valid && !notify_pulse, "R1 reset outputs", {62'b0, rsp_valid, notify_pulse}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v = VEC[i];
            logic [63:0] exp_d = v.e ? '1 : {62'b0, v.d};
            string t = req_tag(v);
            issue(v.we, 4'd8, a0(int'(v.idx), v.odd, v.off));
            check(rsp_valid, $sformatf("R3 vec%0d rsp_valid", i), 64'(rsp_valid), 64'd1);
            check(rsp_data == exp_d, $sformatf("%s vec%0d data", t, i), rsp_data, exp_d);
            check(rsp_err == v.e, $sformatf("%s vec%0d err", t, i), 64'(rsp_err), 64'(v.e));
            check(notify_pulse == v.n, $sformatf("%s vec%0d notify", t, i),
                  64'(notify_pulse), 64'(v.n));
            if (v.n) begin
                check(notify_queue == v.idx[2:0] && notify_escal == v.odd,
                      $sformatf("R11 vec%0d source", i), {60'b0, notify_escal, notify_queue},
                      {60'b0, v.odd, v.idx[2:0]});
            end
        end

        // R3: idle cycle after a response has no response
        @(negedge clk);
        check(!rsp_valid, "R3 idle no rsp", 64'(rsp_valid), 64'd0);

        // R10: wrong access size rejected, state untouched (queue 2 even is 00)
        issue(1'b1, 4'd4, a0(2, 1'b0, 12'h000));
        check(rsp_err && rsp_data == '1, "R10 size4 err", rsp_data, '1);
        check(!notify_pulse, "R10 size4 no notify", 64'(notify_pulse), 64'd0);
        issue(1'b0, 4'd8, a0(2, 1'b0, 12'h800));
        check(rsp_data == 64'd0, "R10 size4 state kept", rsp_data, 64'd0);

        // R2: 64 KiB pages, middle address bits ignored
        issue1(1'b1, AW1'((1 << 17) | (1 << 16)));
        check(b_notify && b_queue == 2'd1 && b_escal, "R2 big page trigger",
              {61'b0, b_escal, b_queue}, 64'd5);
        issue1(1'b0, AW1'((1 << 17) | 12'h800));
        check(b_data == 64'd0, "R2 big page even untouched", b_data, 64'd0);
        issue1(1'b0, AW1'((1 << 17) | (1 << 16) | (5 << 12) | 12'h800));
        check(b_data == 64'd2 && !b_rsp_err, "R2 big page mid bits", b_data, 64'd2);

        // R1: reset mid-run returns every state to 00
        issue(1'b1, 4'd8, a0(4, 1'b1, 12'h000));
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(!rsp_valid, "R1 rsp low in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        issue(1'b0, 4'd8, a0(4, 1'b1, 12'h800));
        check(rsp_data == 64'd0, "R1 odd state cleared", rsp_data, 64'd0);
        issue(1'b0, 4'd8, a0(2, 1'b1, 12'h800));
        check(rsp_data == 64'd0, "R1 q2 odd cleared", rsp_data, 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule